// File: doc/BRIEF.md
# Block Memory Transfer Engine

This block moves a run of bytes from one region of a 16-bit byte-addressed space to another, one byte at a time, over a simple synchronous memory port. A single-cycle start command loads a stepping mode, a source base, a destination base and a byte count. From then on the engine runs on its own until the count is used up. It then drops busy and raises a one-cycle done pulse.

Each byte occupies a fixed slot of six clock cycles: a read, a capture of the returned data, a write, and three quiet cycles. Source and destination addresses each follow their own stepping rule: increment, decrement, alternate (toggling between base and base+1) or fixed. The choice of rule comes from the mode. While a copy is in progress the engine holds an interrupt-inhibit output, so the surrounding processor cannot take an interrupt part-way through a transfer.

Top module: `blkxfer_engine`

## Requirements
- R1: When idle, a start with a valid mode is accepted at the clock edge; busy is high from the next cycle, and the first read is issued in that cycle.
- R2: Mode codes: 0 = source increment, destination increment; 1 = both decrement; 2 = source alternate, destination increment; 3 = source increment, destination alternate; 4 = source increment, destination fixed.
- R3: For byte n (counting from 0), an incrementing address is base+n and a decrementing one is base-n, both wrapping modulo 65536.
- R4: An alternating address for byte n is base + (n mod 2).
- R5: A fixed destination receives every byte at its base address.
- R6: Byte n occupies busy cycles 6n+1 to 6n+6. The read strobe (source address on the port) is high only in the first of these cycles and the write strobe (destination address, captured data) only in the third. A transfer of L bytes keeps busy high for exactly 6L cycles.
- R7: The interrupt-inhibit output is high in every busy cycle and low otherwise.
- R8: Done is high for exactly one cycle, the first cycle after busy falls.
- R9: A start that arrives while busy has no effect on the running transfer's addresses, data or duration.
- R10: A length of 0 means 65536 bytes.
- R11: A start carrying mode code 5, 6 or 7 is ignored, and the engine stays idle.
- R12: After reset, busy, done, the interrupt inhibit and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start command strobe |
| mode | input | 3 | Stepping mode code |
| src_base | input | 16 | Source start address |
| dst_base | input | 16 | Destination start address |
| length | input | 16 | Byte count, 0 means 65536 |
| busy | output | 1 | Transfer in progress |
| irq_inhibit | output | 1 | Interrupt acceptance masked |
| done | output | 1 | One-cycle completion pulse |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_rd |

## Verification
The bench aims at address wrap past 0xFFFF and below 0x0000, and at overlapping regions. In those cases an engine that stepped wrongly or reordered reads and writes would write the wrong address or copy stale data. It checks the alternating parity on both sides. Getting this wrong would put odd-numbered bytes on the base address or drift further than base+1. It also pokes start mid-transfer and with reserved mode codes, where a careless engine would restart or reload its bases. A zero length must still be running after hundreds of bytes, which catches an engine that treats it as a no-op or a single byte.

// File: rtl/blkxfer_engine.sv
module blkxfer_engine #(
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter int SLOT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    mode,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  input  logic [AW-1:0] length,
  output logic          busy,
  output logic          irq_inhibit,
  output logic          done,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  localparam int PW = $clog2(SLOT);
  localparam logic [1:0] K_INC = 2'd0, K_DEC = 2'd1, K_ALT = 2'd2, K_FIX = 2'd3;

  logic [2:0]    mode_q;
  logic [AW-1:0] sb_q, db_q, idx, last;
  logic [PW-1:0] phase;
  logic [DW-1:0] data_q;
  logic [1:0]    skind, dkind;
  logic [AW-1:0] src_addr, dst_addr;

  function automatic logic [AW-1:0] walk(input logic [AW-1:0] b, input logic [1:0] k,
                                         input logic [AW-1:0] n);
    case (k)
      K_INC:   walk = b + n;
      K_DEC:   walk = b - n;
      K_ALT:   walk = b + {{(AW-1){1'b0}}, n[0]};
      default: walk = b;
    endcase
  endfunction

  always_comb begin
    case (mode_q)
      3'd1:    begin skind = K_DEC; dkind = K_DEC; end
      3'd2:    begin skind = K_ALT; dkind = K_INC; end
      3'd3:    begin skind = K_INC; dkind = K_ALT; end
      3'd4:    begin skind = K_INC; dkind = K_FIX; end
      default: begin skind = K_INC; dkind = K_INC; end
    endcase
  end

  assign src_addr    = walk(sb_q, skind, idx);
  assign dst_addr    = walk(db_q, dkind, idx);
  assign mem_rd      = busy && phase == PW'(0);
  assign mem_wr      = busy && phase == PW'(2);
  assign mem_addr    = mem_wr ? dst_addr : src_addr;
  assign mem_wdata   = data_q;
  assign irq_inhibit = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      mode_q <= '0;
      sb_q   <= '0;
      db_q   <= '0;
      idx    <= '0;
      last   <= '0;
      phase  <= '0;
      data_q <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start && mode <= 3'd4) begin
          busy   <= 1'b1;
          mode_q <= mode;
          sb_q   <= src_base;
          db_q   <= dst_base;
          last   <= length - AW'(1);
          idx    <= '0;
          phase  <= '0;
        end
      end else begin
        if (phase == PW'(1)) data_q <= mem_rdata;
        if (phase == PW'(SLOT-1)) begin
          phase <= '0;
          if (idx == last) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            idx <= idx + AW'(1);
          end
        end else begin
          phase <= phase + PW'(1);
        end
      end
    end
  end

  p_wr_follows_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd, 2));
  p_strobes_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));
  p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !(phase == PW'(SLOT-1) && idx == last)) |=> (busy && $stable(sb_q) && $stable(db_q)));
  p_bad_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && mode > 3'd4) |=> !busy);
endmodule

// File: tb/test_blkxfer_engine.sv
`timescale 1ns/1ps
module test_blkxfer_engine;
  logic        clk = 0, rst_n = 0, start = 0;
  logic [2:0]  mode = 0;
  logic [15:0] src_base = 0, dst_base = 0, length = 0;
  logic        busy, irq_inhibit, done, mem_rd, mem_wr;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata = 0;
  int errors = 0, checks = 0;

  logic [7:0] mem   [0:4095];
  logic [7:0] ref_m [0:4095];
  logic [2:0] cur_mode;
  logic [15:0] cur_src, cur_dst;
  int wr_n = 0;

  always #4 clk = ~clk;

  blkxfer_engine i_blkxfer_engine (.*);

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];
    if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;
  end

  function automatic logic [15:0] exp_addr(input logic [15:0] b, input int kind, input int n);
    if (kind == 0) return b + 16'(n);
    if (kind == 1) return b - 16'(n);
    if (kind == 2) return (n % 2 == 1) ? b + 16'd1 : b;
    return b;
  endfunction
  function automatic int src_kind(input logic [2:0] m);
    return (m == 1) ? 1 : (m == 2) ? 2 : 0;
  endfunction
  function automatic int dst_kind(input logic [2:0] m);
    return (m == 1) ? 1 : (m == 3) ? 2 : (m == 4) ? 3 : 0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_wr) begin
      logic [15:0] ea, sa;
      logic [7:0] ed;
      sa = exp_addr(cur_src, src_kind(cur_mode), wr_n);
      ea = exp_addr(cur_dst, dst_kind(cur_mode), wr_n);
      ed = ref_m[sa[11:0]];
      ref_m[ea[11:0]] = ed;
      chk(mem_addr == ea, "R3/R4/R5 write address", mem_addr, ea);
      chk(mem_wdata == ed, "R2/R9 write data", mem_wdata, ed);
      wr_n++;
    end
  end

  task automatic run_xfer(input logic [2:0] m, input logic [15:0] s, input logic [15:0] d,
                          input int l, input bit poke);
    int cyc = 0;
    bit bad_irq = 0, bad_rd = 0, bad_wr = 0;
    cur_mode = m; cur_src = s; cur_dst = d; wr_n = 0;
    mode = m; src_base = s; dst_base = d; length = 16'(l); start = 1;
    @(negedge clk);
    start = 0;
    chk(busy === 1'b1, "R1 busy after start", busy, 1);
    while (busy && cyc < 100000) begin
      cyc++;
      if (irq_inhibit !== 1'b1) bad_irq = 1;
      if (mem_rd !== ((cyc - 1) % 6 == 0)) bad_rd = 1;
      if (mem_wr !== ((cyc - 1) % 6 == 2)) bad_wr = 1;
      if (mem_rd && mem_addr != exp_addr(s, src_kind(m), (cyc - 1) / 6)) bad_rd = 1;
      start = 0;
      if (poke && (cyc == 8 || cyc == 13)) begin
        start = 1; mode = 3'd1; src_base = 16'h0123; dst_base = 16'h0456; length = 16'd2;
      end
      @(negedge clk);
    end
    start = 0;
    chk(!bad_irq, "R7 inhibit during busy", bad_irq, 0);
    chk(!bad_rd, "R6 read slot cycle/address", bad_rd, 0);
    chk(!bad_wr, "R6 write slot cycle", bad_wr, 0);
    chk(cyc == 6 * l, "R6/R9 busy length", cyc, 6 * l);
    chk(wr_n == l, "R6 byte count", wr_n, l);
    chk(done === 1'b1 && irq_inhibit === 1'b0, "R8 done after last", done, 1);
    @(negedge clk);
    chk(done === 1'b0, "R8 done single cycle", done, 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4096; i++) begin
      mem[i] = 8'(i * 37 + (i >> 4));
      ref_m[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    chk(!busy && !done && !irq_inhibit && !mem_rd && !mem_wr, "R12 reset state",
        {busy, done, irq_inhibit, mem_rd, mem_wr}, 0);
    rst_n = 1;
    @(negedge clk);

    run_xfer(3'd0, 16'h0100, 16'h0200, 9, 0);      // R3 increment
    run_xfer(3'd0, 16'hFFFE, 16'h0300, 4, 0);      // R3 wrap up
    run_xfer(3'd1, 16'h0002, 16'h0401, 5, 0);      // R3 wrap down
    run_xfer(3'd2, 16'h0500, 16'h0600, 7, 0);      // R4 source alternate
    run_xfer(3'd3, 16'h0700, 16'h0800, 6, 0);      // R4 destination alternate
    run_xfer(3'd4, 16'h0900, 16'h0A00, 5, 0);      // R5 fixed destination
    run_xfer(3'd0, 16'h0B00, 16'h0B01, 8, 0);      // overlap
    run_xfer(3'd0, 16'h0C00, 16'h0D00, 4, 1);      // R9 start while busy
    run_xfer(3'd0, 16'h0E00, 16'h0E80, 1, 0);      // single byte

    for (int k = 5; k < 8; k++) begin               // R11 reserved modes
      mode = 3'(k); src_base = 16'h0100; dst_base = 16'h0200; length = 16'd3; start = 1;
      @(negedge clk);
      start = 0;
      chk(!busy && !mem_rd && !irq_inhibit, "R11 reserved mode ignored", busy, 0);
      repeat (4) @(negedge clk);
      chk(!busy && !done, "R11 stays idle", busy, 0);
    end

    for (int t = 0; t < 20; t++) begin
      logic [2:0] m;
      m = 3'($urandom_range(0, 4));
      run_xfer(m, 16'($urandom), 16'($urandom), $urandom_range(1, 40), t % 5 == 0);
    end

    // R10 zero length: still running after 700 bytes, then aborted by reset
    cur_mode = 0; cur_src = 16'h0F00; cur_dst = 16'h0100; wr_n = 0;
    mode = 0; src_base = 16'h0F00; dst_base = 16'h0100; length = 16'd0; start = 1;
    @(negedge clk);
    start = 0;
    repeat (6 * 700 - 1) @(negedge clk);
    chk(busy === 1'b1, "R10 zero length still busy", busy, 1);
    chk(wr_n == 700, "R10 zero length write count", wr_n, 700);
    rst_n = 0;
    @(negedge clk);
    @(negedge clk);
    chk(!busy && !irq_inhibit && !done, "R12 reset mid transfer", busy, 0);
    rst_n = 1;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule